// File: doc/BRIEF.md
# SECDED Guard for a 64-bit Word Store

This block sits between a requester and a word-organised memory whose check bits live in an array of their own, beside the data array. Every 64-bit word is protected by eight check bits: seven Hamming bits that locate a flipped bit, plus one bit that makes the parity of the whole 72-bit codeword even. On a full-word write the block computes the check byte and writes data and check byte together. On a read it recomputes the check bits from the returned data, compares them with the stored ones, and classifies the word. The classes are clean, single-bit error (corrected) and double-bit error (uncorrectable).

A corrected word goes only to the requester. The stored copy keeps its flipped bit, so a later read of the same word reports the error again. Corrected and uncorrectable events each set a sticky flag, and each flag holds the address of the first word that raised it. Either flag drives an interrupt line, and each flag is cleared by its own write-one-to-clear pulse. A write that does not enable all eight byte lanes becomes a read-modify-write of the whole word, so the check byte always covers all 64 data bits.

Top module: `ecc_guard`

## Requirements
- R1: A full-word write (`wr_be` all ones) drives the data array with `wr_data` unchanged and the check array with a byte that gives the 72-bit word {check, data} even parity. An all-zero word has an all-zero check byte.
- R2: A read accepted at a clock edge returns `rd_valid` high for exactly one cycle, one edge later. For a clean word, `rd_data` equals the stored data and `rd_ce` and `rd_ue` are low.
- R3: When exactly one data bit of the stored word is flipped, the read returns the originally written data with `rd_ce` high and `rd_ue` low.
- R4: When exactly one check bit is flipped, the read returns the stored data unchanged with `rd_ce` high and `rd_ue` low.
- R5: When two bits of the 72-bit word are flipped, whether data or check bits, the read reports `rd_ue` high and `rd_ce` low. `rd_ce` and `rd_ue` are never high together.
- R6: A read never drives a write into storage. The stored copy keeps its error, and a repeated read reports the error again.
- R7: `ce_flag` and `ue_flag` set on the edge that reports a corrected or uncorrectable event. While set, `ce_addr` and `ue_addr` keep the address of the first such event.
- R8: A high `clr_ce` or `clr_ue` clears its flag. If a new event of that kind arrives at the same edge, the flag stays set and captures the new address.
- R9: `irq` is high exactly when `ce_flag` or `ue_flag` is set.
- R10: A write with some `wr_be` bits low reads the word, replaces the byte lanes whose `wr_be` bit is high (lane n is bits 8n+7..8n), and writes back a clean codeword. `ready` is low for the one cycle in between.
- R11: If the word read for a partial write holds a single-bit error, the corrected, merged word is written and a corrected event is raised. If it holds a double-bit error, nothing is written and an uncorrectable event is raised.
- R12: When `rd_req` and `wr_req` are both high while `ready` is high, the read is taken and the write is not accepted in that cycle.
- R13: Check bit j (j = 0..6) is the Hamming parity at codeword position 2^j. Data bit i sits at the i-th non-power-of-two position, counting upward from 3, so data bit 0 is at position 3 and data bit 63 at position 71. Check bit 7 is the overall parity. Data 1 therefore encodes to check byte 0x83, and data 1<<63 encodes to 0xC7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, taken when `ready` is high |
| rd_addr | input | ADDR_W | Read word address |
| wr_req | input | 1 | Write request, taken when `ready` is high and `rd_req` is low |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 64 | Write data |
| wr_be | input | 8 | Byte-lane enables for the write |
| ready | output | 1 | Block is idle and can take a request |
| rd_valid | output | 1 | Read response valid for one cycle |
| rd_data | output | 64 | Read data, corrected when possible |
| rd_ce | output | 1 | Response carried a corrected single-bit error |
| rd_ue | output | 1 | Response carried an uncorrectable error |
| mem_en | output | 1 | Storage access strobe |
| mem_we | output | 1 | Storage write (high) or read (low) |
| mem_addr | output | ADDR_W | Storage word address, shared by both arrays |
| mem_wdata | output | 64 | Data array write value |
| chk_wdata | output | 8 | Check array write value |
| mem_rdata | input | 64 | Data array read value, one cycle after the strobe |
| chk_rdata | input | 8 | Check array read value, one cycle after the strobe |
| clr_ce | input | 1 | Write-one-to-clear for the corrected flag |
| clr_ue | input | 1 | Write-one-to-clear for the uncorrectable flag |
| ce_flag | output | 1 | Sticky corrected-error flag |
| ce_addr | output | ADDR_W | Address of the first corrected error |
| ue_flag | output | 1 | Sticky uncorrectable-error flag |
| ue_addr | output | ADDR_W | Address of the first uncorrectable error |
| irq | output | 1 | Interrupt, high while either flag is set |

## Verification
The hardest situations to reach from the ports are a stored codeword that is already wrong, and a clear pulse that lands on the same edge as a new event. The block only ever writes clean codewords. The bench therefore models both storage arrays itself and flips chosen data or check bits directly in its model between the write and the read. A vector table walks single flips at the data ends, in the check bits and in the overall parity bit, and also double flips mixed across the two arrays. Directed sequences then time `clr_ce` onto the response edge of a failing read and run partial writes onto words that already hold one and two flipped bits.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

    localparam int DATA_W   = 64;
    localparam int HAM_W    = 7;
    localparam int CHK_W    = HAM_W + 1;
    localparam int LANE_W   = 8;
    localparam int LANES    = DATA_W / LANE_W;
    localparam int LAST_POS = DATA_W + HAM_W;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_WAIT  = 2'd1,
        ST_RMW_WAIT = 2'd2
    } state_e;

    // Codeword position of data bit idx: the idx-th non power of two from 3.
    function automatic logic [HAM_W-1:0] data_pos(input int idx);
        int p;
        p = 2;
        for (int i = 0; i < DATA_W; i++) begin
            p = p + 1;
            if ((p & (p - 1)) == 0) p = p + 1;
            if (i == idx) break;
        end
        return p[HAM_W-1:0];
    endfunction

    // Hamming bits: XOR of the positions of all set data bits.
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) h = h ^ data_pos(i);
        end
        return h;
    endfunction

    function automatic logic [CHK_W-1:0] encode(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = ham_bits(d);
        return {(^d) ^ (^h), h};
    endfunction

endpackage

// File: rtl/ecc_guard_enc.sv
module ecc_guard_enc
    import ecc_guard_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    always_comb begin
        chk_o = encode(data_i);
    end
endmodule

// File: rtl/ecc_guard_dec.sv
module ecc_guard_dec
    import ecc_guard_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    logic [HAM_W-1:0] syn;
    logic             par_bad;
    logic             in_range;

    always_comb begin
        syn      = ham_bits(data_i) ^ chk_i[HAM_W-1:0];
        par_bad  = (^data_i) ^ (^chk_i);
        in_range = (int'(syn) <= LAST_POS);
        single_o = par_bad && in_range;
        double_o = (!par_bad && (syn != '0)) || (par_bad && !in_range);
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_fix
        localparam logic [HAM_W-1:0] POS = data_pos(g);
        assign data_o[g] = data_i[g] ^ (single_o && (syn == POS));
    end
endmodule

// File: rtl/ecc_guard_status.sv
module ecc_guard_status #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              clr_ce,
    input  logic              clr_ue,
    output logic              ce_flag,
    output logic [ADDR_W-1:0] ce_addr,
    output logic              ue_flag,
    output logic [ADDR_W-1:0] ue_addr
);
    typedef struct packed {
        logic              ce;
        logic [ADDR_W-1:0] ce_addr;
        logic              ue;
        logic [ADDR_W-1:0] ue_addr;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_ce) st_d.ce = 1'b0;
        if (clr_ue) st_d.ue = 1'b0;
        if (ev_ce && (!st_q.ce || clr_ce)) begin
            st_d.ce      = 1'b1;
            st_d.ce_addr = ev_addr;
        end
        if (ev_ue && (!st_q.ue || clr_ue)) begin
            st_d.ue      = 1'b1;
            st_d.ue_addr = ev_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ce_flag = st_q.ce;
    assign ce_addr = st_q.ce_addr;
    assign ue_flag = st_q.ue;
    assign ue_addr = st_q.ue_addr;
endmodule

// File: rtl/ecc_guard.sv
module ecc_guard
    import ecc_guard_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_be,
    output logic              ready,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              rd_ce,
    output logic              rd_ue,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    output logic [7:0]        chk_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic [7:0]        chk_rdata,
    input  logic              clr_ce,
    input  logic              clr_ue,
    output logic              ce_flag,
    output logic [ADDR_W-1:0] ce_addr,
    output logic              ue_flag,
    output logic [ADDR_W-1:0] ue_addr,
    output logic              irq
);
    typedef struct packed {
        state_e              state;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    wbe;
        logic                rd_valid;
        logic [DATA_W-1:0]   rd_data;
        logic                rd_ce;
        logic                rd_ue;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0] enc_in;
    logic [CHK_W-1:0]  enc_chk;
    logic [DATA_W-1:0] dec_fix;
    logic              dec_single;
    logic              dec_double;
    logic [DATA_W-1:0] merged;
    logic              ev_ce;
    logic              ev_ue;

    ecc_guard_enc u_enc (
        .data_i (enc_in),
        .chk_o  (enc_chk)
    );

    ecc_guard_dec u_dec (
        .data_i   (mem_rdata),
        .chk_i    (chk_rdata),
        .data_o   (dec_fix),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] = r_q.wbe[l] ? r_q.wdata[l*LANE_W +: LANE_W]
                                                       : dec_fix[l*LANE_W +: LANE_W];
    end

    always_comb begin
        r_d        = r_q;
        r_d.rd_valid = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = r_q.addr;
        enc_in     = wr_data;
        ev_ce      = 1'b0;
        ev_ue      = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (rd_req) begin
                    mem_en    = 1'b1;
                    mem_addr  = rd_addr;
                    r_d.addr  = rd_addr;
                    r_d.state = ST_RD_WAIT;
                end else if (wr_req) begin
                    mem_en   = 1'b1;
                    mem_addr = wr_addr;
                    if (&wr_be) begin
                        mem_we = 1'b1;
                    end else begin
                        r_d.addr  = wr_addr;
                        r_d.wdata = wr_data;
                        r_d.wbe   = wr_be;
                        r_d.state = ST_RMW_WAIT;
                    end
                end
            end
            ST_RD_WAIT: begin
                r_d.rd_valid = 1'b1;
                r_d.rd_data  = dec_fix;
                r_d.rd_ce    = dec_single;
                r_d.rd_ue    = dec_double;
                ev_ce        = dec_single;
                ev_ue        = dec_double;
                r_d.state    = ST_IDLE;
            end
            ST_RMW_WAIT: begin
                enc_in = merged;
                ev_ce  = dec_single;
                ev_ue  = dec_double;
                if (!dec_double) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                end
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    ecc_guard_status #(.ADDR_W(ADDR_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_ce   (ev_ce),
        .ev_ue   (ev_ue),
        .ev_addr (r_q.addr),
        .clr_ce  (clr_ce),
        .clr_ue  (clr_ue),
        .ce_flag (ce_flag),
        .ce_addr (ce_addr),
        .ue_flag (ue_flag),
        .ue_addr (ue_addr)
    );

    assign mem_wdata = enc_in;
    assign chk_wdata = enc_chk;
    assign ready     = (r_q.state == ST_IDLE);
    assign rd_valid  = r_q.rd_valid;
    assign rd_data   = r_q.rd_data;
    assign rd_ce     = r_q.rd_ce;
    assign rd_ue     = r_q.rd_ue;
    assign irq       = ce_flag | ue_flag;
endmodule

// File: rtl/ecc_guard_chk.sv
module ecc_guard_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              wr_req,
    input logic [7:0]        wr_be,
    input logic              ready,
    input logic              mem_en,
    input logic              mem_we,
    input logic              rd_valid,
    input logic              rd_ce,
    input logic              rd_ue,
    input logic              clr_ce,
    input logic              ce_flag,
    input logic [ADDR_W-1:0] ce_addr,
    input logic              ue_flag
);
    // R2: a response lasts one cycle
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5: the two error classes exclude each other
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !(rd_ce && rd_ue));

    // R6: the cycle after a read is taken never writes storage
    a_r6_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_req) |=> !mem_we);

    // R7: a reported event is visible in the sticky flag
    a_r7_ce_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ce) |-> ce_flag);

    a_r7_ue_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ue) |-> ue_flag);

    // R7: first address held while the flag stays set and no clear occurs
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_flag && !clr_ce) |=> (!ce_flag || $stable(ce_addr)));

    // R10: a partial write takes one extra busy cycle
    a_r10_rmw_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_req && !rd_req && (wr_be != 8'hFF)) |=> !ready);

    // R12: read wins over a simultaneous write
    a_r12_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_req && wr_req) |-> (mem_en && !mem_we));
endmodule

bind ecc_guard ecc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .wr_be    (wr_be),
    .ready    (ready),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .rd_valid (rd_valid),
    .rd_ce    (rd_ce),
    .rd_ue    (rd_ue),
    .clr_ce   (clr_ce),
    .ce_flag  (ce_flag),
    .ce_addr  (ce_addr),
    .ue_flag  (ue_flag)
);

// File: tb/ecc_guard_bench.sv
`timescale 1ns/1ps
module ecc_guard_bench;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0, wr_req = 1'b0, clr_ce = 1'b0, clr_ue = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic [63:0]   wr_data = '0;
    logic [7:0]    wr_be = '0;
    logic          ready, rd_valid, rd_ce, rd_ue, mem_en, mem_we;
    logic          ce_flag, ue_flag, irq;
    logic [AW-1:0] mem_addr, ce_addr, ue_addr;
    logic [63:0]   rd_data, mem_wdata, mem_rdata;
    logic [7:0]    chk_wdata, chk_rdata;

    logic [63:0] dmem [0:(1<<AW)-1];
    logic [7:0]  cmem [0:(1<<AW)-1];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ecc_guard #(.ADDR_W(AW)) u_ecc_guard (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ce(rd_ce),
        .rd_ue(rd_ue), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .chk_wdata(chk_wdata), .mem_rdata(mem_rdata),
        .chk_rdata(chk_rdata), .clr_ce(clr_ce), .clr_ue(clr_ue),
        .ce_flag(ce_flag), .ce_addr(ce_addr), .ue_flag(ue_flag),
        .ue_addr(ue_addr), .irq(irq)
    );

    // Storage model: separate data and check arrays, one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                dmem[mem_addr] <= mem_wdata;
                cmem[mem_addr] <= chk_wdata;
            end else begin
                mem_rdata <= dmem[mem_addr];
                chk_rdata <= cmem[mem_addr];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_req = 1'b0;
        if (be != 8'hFF) begin
            check(ready == 1'b0, "R10 busy", {63'd0, ready}, 64'd0);
            @(negedge clk);
        end
    endtask

    // Read; optionally pulse clr_ce onto the response edge
    task automatic do_read(input logic [AW-1:0] a, input bit clr_on_resp);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        if (rd_valid) check(1'b0, "R2 early valid", 64'd1, 64'd0);
        clr_ce = clr_on_resp;
        @(negedge clk);
        clr_ce = 1'b0;
        check(rd_valid == 1'b1, "R2 valid", {63'd0, rd_valid}, 64'd1);
    endtask

    task automatic flip(input logic [AW-1:0] a, input int idx);
        if (idx >= 0 && idx < 64) dmem[a][idx] = ~dmem[a][idx];
        else if (idx >= 64)       cmem[a][idx-64] = ~cmem[a][idx-64];
    endtask

    task automatic pulse_clear(input bit c, input bit u);
        @(negedge clk);
        clr_ce = c; clr_ue = u;
        @(negedge clk);
        clr_ce = 1'b0; clr_ue = 1'b0;
    endtask

    typedef struct packed {
        logic [63:0] data;
        int          fa;
        int          fb;
        logic        ce;
        logic        ue;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_0000, -1, -1, 1'b0, 1'b0},  // R1 R2
        '{64'hFFFF_FFFF_FFFF_FFFF, -1, -1, 1'b0, 1'b0},
        '{64'h0123_4567_89AB_CDEF, -1, -1, 1'b0, 1'b0},
        '{64'hDEAD_BEEF_CAFE_F00D,  0, -1, 1'b1, 1'b0},  // R3
        '{64'h8000_0000_0000_0001, 63, -1, 1'b1, 1'b0},
        '{64'hA5A5_A5A5_A5A5_A5A5, 31, -1, 1'b1, 1'b0},
        '{64'h0F0F_0F0F_0F0F_0F0F, 64, -1, 1'b1, 1'b0},  // R4
        '{64'h3C3C_3C3C_3C3C_3C3C, 71, -1, 1'b1, 1'b0},
        '{64'h1122_3344_5566_7788,  3, 40, 1'b0, 1'b1},  // R5
        '{64'hFEDC_BA98_7654_3210, 10, 66, 1'b0, 1'b1},
        '{64'h5555_5555_5555_5555, 64, 71, 1'b0, 1'b1}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready && !rd_valid && !ce_flag && !ue_flag && !irq, "reset state",
              {59'd0, ready, rd_valid, ce_flag, ue_flag, irq}, 64'h10);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_write(AW'(i), VECS[i].data, 8'hFF);
            check(dmem[i] == VECS[i].data, "R1 data stored", dmem[i], VECS[i].data);
            check((^{cmem[i], dmem[i]}) == 1'b0, "R1 even parity", {56'd0, cmem[i]}, 64'd0);
            flip(AW'(i), VECS[i].fa);
            flip(AW'(i), VECS[i].fb);
            held = dmem[i];
            do_read(AW'(i), 1'b0);
            check(rd_ce == VECS[i].ce, "R3 R4 corrected flag", {63'd0, rd_ce}, {63'd0, VECS[i].ce});
            check(rd_ue == VECS[i].ue, "R5 uncorrectable flag", {63'd0, rd_ue}, {63'd0, VECS[i].ue});
            if (!VECS[i].ue)
                check(rd_data == VECS[i].data, "R2 R3 R4 data", rd_data, VECS[i].data);
            check(dmem[i] == held, "R6 stored copy unchanged", dmem[i], held);
        end
        check(cmem[0] == 8'h00, "R1 zero word check byte", {56'd0, cmem[0]}, 64'd0);

        // R6: error persists on a repeat read
        do_read(AW'(3), 1'b0);
        check(rd_ce && rd_data == VECS[3].data, "R6 repeat read", rd_data, VECS[3].data);

        // R7 / R9: first addresses held
        check(ce_flag && ce_addr == AW'(3), "R7 ce first addr", {58'd0, ce_addr}, 64'd3);
        check(ue_flag && ue_addr == AW'(8), "R7 ue first addr", {58'd0, ue_addr}, 64'd8);
        check(irq == 1'b1, "R9 irq set", {63'd0, irq}, 64'd1);

        // R8 / R9: clears
        pulse_clear(1'b1, 1'b0);
        check(!ce_flag && ue_flag && irq, "R8 clear ce", {61'd0, ce_flag, ue_flag, irq}, 64'h3);
        pulse_clear(1'b0, 1'b1);
        check(!ue_flag && !irq, "R9 irq clear", {62'd0, ue_flag, irq}, 64'd0);

        // R8: event at the same edge as a clear wins
        do_read(AW'(5), 1'b0);
        do_read(AW'(4), 1'b1);
        check(ce_flag && ce_addr == AW'(4), "R8 event beats clear", {58'd0, ce_addr}, 64'd4);
        pulse_clear(1'b1, 1'b1);

        // R13: bit placement
        do_write(AW'(30), 64'h1, 8'hFF);
        check(cmem[30] == 8'h83, "R13 data bit 0", {56'd0, cmem[30]}, 64'h83);
        do_write(AW'(31), 64'h8000_0000_0000_0000, 8'hFF);
        check(cmem[31] == 8'hC7, "R13 data bit 63", {56'd0, cmem[31]}, 64'hC7);

        // R10: partial write merge
        do_write(AW'(20), 64'h1111_2222_3333_4444, 8'hFF);
        do_write(AW'(20), 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);
        check(dmem[20] == 64'h1111_2222_CCCC_DDDD, "R10 merged", dmem[20], 64'h1111_2222_CCCC_DDDD);
        check((^{cmem[20], dmem[20]}) == 1'b0, "R10 clean codeword", {56'd0, cmem[20]}, 64'd0);
        do_read(AW'(20), 1'b0);
        check(!rd_ce && !rd_ue && rd_data == 64'h1111_2222_CCCC_DDDD, "R10 readback",
              rd_data, 64'h1111_2222_CCCC_DDDD);

        // R11: partial write onto a single error
        do_write(AW'(21), 64'h0000_1234_5678_9ABC, 8'hFF);
        flip(AW'(21), 50);
        do_write(AW'(21), 64'h0000_0000_0000_00EE, 8'h01);
        check(dmem[21] == 64'h0000_1234_5678_9AEE, "R11 corrected merge", dmem[21], 64'h0000_1234_5678_9AEE);
        check((^{cmem[21], dmem[21]}) == 1'b0, "R11 clean after merge", {56'd0, cmem[21]}, 64'd0);
        check(ce_flag && ce_addr == AW'(21), "R11 ce event", {58'd0, ce_addr}, 64'd21);

        // R11: partial write onto a double error is dropped
        do_write(AW'(22), 64'h7777_6666_5555_4444, 8'hFF);
        flip(AW'(22), 1); flip(AW'(22), 2);
        held = dmem[22];
        do_write(AW'(22), 64'hFFFF_FFFF_FFFF_FFFF, 8'hF0);
        check(dmem[22] == held, "R11 no write on double", dmem[22], held);
        check(ue_flag && ue_addr == AW'(22), "R11 ue event", {58'd0, ue_addr}, 64'd22);

        // R12: read wins over a simultaneous write
        do_write(AW'(25), 64'h0BAD_F00D_0BAD_F00D, 8'hFF);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(25);
        wr_req = 1'b1; wr_addr = AW'(25); wr_data = 64'h1; wr_be = 8'hFF;
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        @(negedge clk);
        check(rd_valid && rd_data == 64'h0BAD_F00D_0BAD_F00D, "R12 read taken", rd_data, 64'h0BAD_F00D_0BAD_F00D);
        check(dmem[25] == 64'h0BAD_F00D_0BAD_F00D, "R12 write not taken", dmem[25], 64'h0BAD_F00D_0BAD_F00D);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule